// File: doc/BRIEF.md
# Loopback Virtual Channel Selector with Source Group Arbiter

This block sits between two receive-side packet lanes and the transmit path. Every packet on a lane carries a virtual channel tag and a data type. The block compares the tag against two programmable channel slots. A packet on the first slot's channel leaves on loopback port A (index 0). A packet on the second slot's channel leaves on loopback port B (index 1). Packets on any other channel, and packets whose data type is not RAW, are consumed and discarded. Forwarding is combinational, so an accepted beat appears on its port in the same cycle it is taken from the lane.

The transmit path carries one virtual channel at a time. The selector therefore forwards one whole packet at a time and alternates between the lanes only at packet boundaries. Three source groups compete for the transmitter: the DMA path, the colour bar generator and this loopback group. A grant register gives the transmitter to one group and keeps it there until that group signals the end of a frame. A request from a group that does not receive the grant raises a sticky conflict flag.

Top module: `lb_vc_selector`

## Requirements
- R1: A beat is forwarded on port A (lb_valid[0]) with its data, sop, eop, frame-end and data type unchanged, in the cycle its lane sees rx_ready. This applies when the packet's channel equals cfg_vc0 and its type is RAW. If cfg_vc0 equals cfg_vc1, port A wins.
- R2: A RAW packet whose channel equals cfg_vc1 and not cfg_vc0 is forwarded the same way on port B (lb_valid[1]).
- R3: A RAW packet on a channel matching neither slot is consumed with rx_ready high from its first beat. It appears on no port and raises no flag.
- R4: RAW means a data type code from 0x28 to 0x2F inclusive. A packet of any other type is consumed without output, whatever its channel, and dt_err is set the cycle after its first beat and stays set until reset.
- R5: At most one of the two loopback ports is valid in any cycle.
- R6: Once a packet has started on one port, the other port stays idle and the other lane is not ready until that packet's eop beat has been forwarded.
- R7: When both lanes hold a wanted packet at a packet boundary, the lane not served last goes next, so the lanes alternate.
- R8: grant is one-hot or zero (bit 0 DMA, bit 1 colour bar, bit 2 loopback). A free grant is taken the cycle after a request. It is then held until the owner's frame-end, and is zero the cycle after that frame-end.
- R9: Loopback beats are forwarded only while grant[2] is set. Otherwise a wanted packet waits with rx_ready low.
- R10: A request from a group that neither holds nor receives the grant sets conflict_err the next cycle. conflict_err stays set until reset.
- R11: When several groups request a free grant in the same cycle, DMA wins over colour bar and colour bar wins over loopback.
- R12: After reset, grant, conflict_err, dt_err, lb_valid and rx_ready are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_vc0 | input | 2 | Channel routed to port A |
| cfg_vc1 | input | 2 | Channel routed to port B |
| rx_valid | input | 2 | Per-lane beat valid |
| rx_ready | output | 2 | Per-lane beat taken (forward or discard) |
| rx_sop | input | 2 | Per-lane first beat of packet |
| rx_eop | input | 2 | Per-lane last beat of packet |
| rx_fend | input | 2 | Per-lane packet is the last of its frame |
| rx_vc | input | 2x2 | Per-lane virtual channel tag |
| rx_dt | input | 2x6 | Per-lane data type code |
| rx_data | input | 2x32 | Per-lane payload word |
| dma_req | input | 1 | DMA group wants the transmitter |
| dma_fend | input | 1 | DMA group frame finished |
| cbar_req | input | 1 | Colour bar group wants the transmitter |
| cbar_fend | input | 1 | Colour bar group frame finished |
| lb_valid | output | 2 | Per-port beat valid (0 = A, 1 = B) |
| lb_sop | output | 2 | Per-port first beat |
| lb_eop | output | 2 | Per-port last beat |
| lb_fend | output | 2 | Per-port frame-end marker |
| lb_dt | output | 2x6 | Per-port data type |
| lb_data | output | 2x32 | Per-port payload word |
| grant | output | 3 | Owning group, one-hot |
| conflict_err | output | 1 | Sticky exclusivity violation |
| dt_err | output | 1 | Sticky non-RAW packet seen |

## Verification
A packet-state register that is wrong shows up in the same cycle as a ready on the wrong lane, or as a valid on both ports or on the wrong port. A drop state that is lost or stuck corrupts the very next beat of that lane. A grant register that is wrong shows one cycle later: a loopback port goes valid without grant[2], or the grant is still held after the owner's frame-end. The round-robin pointer is checked by forcing both lanes to compete on every packet, so a single wrong choice breaks the expected alternation at once.

// File: rtl/lbsel_pkg.sv
`timescale 1ns/1ps
package lbsel_pkg;
    localparam int VC_W   = 2;
    localparam int DT_W   = 6;
    localparam int DATA_W = 32;
    localparam int NLANE  = 2;
    localparam int NGRP   = 3;

    typedef enum logic [1:0] {
        GRP_DMA  = 2'd0,
        GRP_CBAR = 2'd1,
        GRP_LB   = 2'd2
    } grp_e;

    // RAW family occupies codes 0x28..0x2F: top three bits 101
    function automatic logic is_raw(input logic [DT_W-1:0] dt);
        return dt[DT_W-1:DT_W-3] == 3'b101;
    endfunction

    function automatic logic [NGRP-1:0] lowest_bit(input logic [NGRP-1:0] v);
        return v & (~v + 1'b1);
    endfunction
endpackage

// File: rtl/lbsel_lane_filter.sv
`timescale 1ns/1ps
module lbsel_lane_filter
    import lbsel_pkg::*;
#(
    parameter int VW = VC_W,
    parameter int DW = DT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          sop,
    input  logic          eop,
    input  logic [VW-1:0] vc,
    input  logic [DW-1:0] dt,
    input  logic [VW-1:0] cfg_vc0,
    input  logic [VW-1:0] cfg_vc1,
    output logic          want,
    output logic          drop,
    output logic          route,
    output logic          bad_dt
);
    logic discarding_q;
    logic head, hit0, hit1, raw_ok, keep;

    always_comb begin
        head   = valid & sop & ~discarding_q;
        hit0   = (vc == cfg_vc0);
        hit1   = (vc == cfg_vc1);
        raw_ok = is_raw(dt);
        keep   = raw_ok & (hit0 | hit1);
        want   = head & keep;
        drop   = discarding_q | (head & ~keep);
        route  = ~hit0;
        bad_dt = head & ~raw_ok;
    end

    always_ff @(posedge clk) begin
        if (rst)
            discarding_q <= 1'b0;
        else if (valid & drop)
            discarding_q <= ~eop;
    end
endmodule

// File: rtl/lbsel_rr_pick.sv
`timescale 1ns/1ps
module lbsel_rr_pick
    import lbsel_pkg::*;
#(
    parameter int NL = NLANE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [NL-1:0] want,
    input  logic [NL-1:0] route,
    input  logic [NL-1:0] valid,
    input  logic [NL-1:0] eop,
    output logic          sel,
    output logic          act,
    output logic          fwd_route
);
    logic busy_q, cur_q, cur_route_q, last_q;
    logic start, pick, done;

    always_comb begin
        if (&want) pick = ~last_q;
        else       pick = want[1];
        start     = ~busy_q & enable & (|want);
        sel       = busy_q ? cur_q : pick;
        act       = busy_q | start;
        fwd_route = busy_q ? cur_route_q : route[pick];
        done      = act & valid[sel] & eop[sel];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            cur_q       <= 1'b0;
            cur_route_q <= 1'b0;
            last_q      <= 1'b1;
        end else if (done) begin
            busy_q <= 1'b0;
            last_q <= sel;
        end else if (start) begin
            busy_q      <= 1'b1;
            cur_q       <= pick;
            cur_route_q <= route[pick];
        end
    end
endmodule

// File: rtl/lbsel_group_arb.sv
`timescale 1ns/1ps
module lbsel_group_arb
    import lbsel_pkg::*;
#(
    parameter int NG = NGRP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NG-1:0] req,
    input  logic [NG-1:0] fend,
    output logic [NG-1:0] grant,
    output logic          conflict
);
    logic [NG-1:0] grant_q, winner;
    logic          free, release_now;

    always_comb begin
        free        = (grant_q == '0);
        release_now = |(grant_q & fend);
        winner      = free ? lowest_bit(req) : grant_q;
        grant       = grant_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q  <= '0;
            conflict <= 1'b0;
        end else begin
            if (release_now)
                grant_q <= '0;
            else if (free)
                grant_q <= winner;
            if (|(req & ~winner))
                conflict <= 1'b1;
        end
    end
endmodule

// File: rtl/lb_vc_selector.sv
`timescale 1ns/1ps
module lb_vc_selector
    import lbsel_pkg::*;
#(
    parameter int VW = VC_W,
    parameter int DW = DT_W,
    parameter int PW = DATA_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [VW-1:0]            cfg_vc0,
    input  logic [VW-1:0]            cfg_vc1,
    input  logic [NLANE-1:0]         rx_valid,
    output logic [NLANE-1:0]         rx_ready,
    input  logic [NLANE-1:0]         rx_sop,
    input  logic [NLANE-1:0]         rx_eop,
    input  logic [NLANE-1:0]         rx_fend,
    input  logic [NLANE-1:0][VW-1:0] rx_vc,
    input  logic [NLANE-1:0][DW-1:0] rx_dt,
    input  logic [NLANE-1:0][PW-1:0] rx_data,
    input  logic                     dma_req,
    input  logic                     dma_fend,
    input  logic                     cbar_req,
    input  logic                     cbar_fend,
    output logic [NLANE-1:0]         lb_valid,
    output logic [NLANE-1:0]         lb_sop,
    output logic [NLANE-1:0]         lb_eop,
    output logic [NLANE-1:0]         lb_fend,
    output logic [NLANE-1:0][DW-1:0] lb_dt,
    output logic [NLANE-1:0][PW-1:0] lb_data,
    output logic [NGRP-1:0]          grant,
    output logic                     conflict_err,
    output logic                     dt_err
);
    logic [NLANE-1:0] want, drop, route, bad_dt;
    logic             sel, act, fwd_route, beat_go, lb_frame_done;
    logic [NGRP-1:0]  grp_req, grp_fend;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        lbsel_lane_filter #(.VW(VW), .DW(DW)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .valid   (rx_valid[i]),
            .sop     (rx_sop[i]),
            .eop     (rx_eop[i]),
            .vc      (rx_vc[i]),
            .dt      (rx_dt[i]),
            .cfg_vc0 (cfg_vc0),
            .cfg_vc1 (cfg_vc1),
            .want    (want[i]),
            .drop    (drop[i]),
            .route   (route[i]),
            .bad_dt  (bad_dt[i])
        );
        assign rx_ready[i] = drop[i] | (act & (sel == i[0]));
    end

    lbsel_rr_pick #(.NL(NLANE)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .enable    (grant[GRP_LB]),
        .want      (want),
        .route     (route),
        .valid     (rx_valid),
        .eop       (rx_eop),
        .sel       (sel),
        .act       (act),
        .fwd_route (fwd_route)
    );

    always_comb begin
        beat_go       = act & rx_valid[sel];
        lb_frame_done = beat_go & rx_eop[sel] & rx_fend[sel];
        grp_req       = '0;
        grp_fend      = '0;
        grp_req[GRP_DMA]   = dma_req;
        grp_req[GRP_CBAR]  = cbar_req;
        grp_req[GRP_LB]    = |want;
        grp_fend[GRP_DMA]  = dma_fend;
        grp_fend[GRP_CBAR] = cbar_fend;
        grp_fend[GRP_LB]   = lb_frame_done;
    end

    for (genvar p = 0; p < NLANE; p++) begin : g_port
        assign lb_valid[p] = beat_go & (fwd_route == p[0]);
        assign lb_sop[p]   = rx_sop[sel];
        assign lb_eop[p]   = rx_eop[sel];
        assign lb_fend[p]  = rx_fend[sel];
        assign lb_dt[p]    = rx_dt[sel];
        assign lb_data[p]  = rx_data[sel];
    end

    lbsel_group_arb #(.NG(NGRP)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .req      (grp_req),
        .fend     (grp_fend),
        .grant    (grant),
        .conflict (conflict_err)
    );

    always_ff @(posedge clk) begin
        if (rst)         dt_err <= 1'b0;
        else if (|bad_dt) dt_err <= 1'b1;
    end
endmodule

// File: rtl/lbsel_checker.sv
`timescale 1ns/1ps
module lbsel_checker
    import lbsel_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic [NLANE-1:0]            lb_valid,
    input logic [NLANE-1:0]            lb_sop,
    input logic [NLANE-1:0]            lb_eop,
    input logic [NLANE-1:0]            lb_fend,
    input logic [NLANE-1:0][DT_W-1:0]  lb_dt,
    input logic [NGRP-1:0]             grant,
    input logic                        dma_fend,
    input logic                        cbar_fend,
    input logic                        conflict_err,
    input logic                        dt_err
);
    logic [NLANE-1:0] open_q;
    logic             owner_fend;

    always_ff @(posedge clk) begin
        if (rst) open_q <= '0;
        else begin
            for (int k = 0; k < NLANE; k++)
                if (lb_valid[k]) open_q[k] <= ~lb_eop[k];
        end
    end

    always_comb
        owner_fend = (grant[GRP_DMA] & dma_fend) | (grant[GRP_CBAR] & cbar_fend)
                   | (grant[GRP_LB] & |(lb_valid & lb_eop & lb_fend));

    assert_one_port_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lb_valid));
    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    assert_grant_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && !owner_fend) |=> grant == $past(grant));
    assert_lb_needs_grant_R9: assert property (@(posedge clk) disable iff (rst)
        (|lb_valid) |-> grant[GRP_LB]);
    assert_conflict_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        conflict_err |=> conflict_err);
    assert_dterr_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        dt_err |=> dt_err);
    assert_raw_only_a_R4: assert property (@(posedge clk) disable iff (rst)
        (lb_valid[0] && lb_sop[0]) |-> is_raw(lb_dt[0]));
    assert_raw_only_b_R4: assert property (@(posedge clk) disable iff (rst)
        (lb_valid[1] && lb_sop[1]) |-> is_raw(lb_dt[1]));
    assert_no_interleave_a_R6: assert property (@(posedge clk) disable iff (rst)
        open_q[0] |-> !lb_valid[1]);
    assert_no_interleave_b_R6: assert property (@(posedge clk) disable iff (rst)
        open_q[1] |-> !lb_valid[0]);
endmodule

bind lb_vc_selector lbsel_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .lb_valid     (lb_valid),
    .lb_sop       (lb_sop),
    .lb_eop       (lb_eop),
    .lb_fend      (lb_fend),
    .lb_dt        (lb_dt),
    .grant        (grant),
    .dma_fend     (dma_fend),
    .cbar_fend    (cbar_fend),
    .conflict_err (conflict_err),
    .dt_err       (dt_err)
);

// File: tb/sim_lb_vc_selector.sv
`timescale 1ns/1ps
module sim_lb_vc_selector;
    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       cfg_vc0, cfg_vc1;
    logic [1:0]       rx_valid, rx_ready, rx_sop, rx_eop, rx_fend;
    logic [1:0][1:0]  rx_vc;
    logic [1:0][5:0]  rx_dt;
    logic [1:0][31:0] rx_data;
    logic             dma_req, dma_fend, cbar_req, cbar_fend;
    logic [1:0]       lb_valid, lb_sop, lb_eop, lb_fend;
    logic [1:0][5:0]  lb_dt;
    logic [1:0][31:0] lb_data;
    logic [2:0]       grant;
    logic             conflict_err, dt_err;

    int nvec = 0;
    int nerr = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    lb_vc_selector u0 (
        .clk(clk), .rst(rst), .cfg_vc0(cfg_vc0), .cfg_vc1(cfg_vc1),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_sop(rx_sop), .rx_eop(rx_eop),
        .rx_fend(rx_fend), .rx_vc(rx_vc), .rx_dt(rx_dt), .rx_data(rx_data),
        .dma_req(dma_req), .dma_fend(dma_fend), .cbar_req(cbar_req), .cbar_fend(cbar_fend),
        .lb_valid(lb_valid), .lb_sop(lb_sop), .lb_eop(lb_eop), .lb_fend(lb_fend),
        .lb_dt(lb_dt), .lb_data(lb_data), .grant(grant),
        .conflict_err(conflict_err), .dt_err(dt_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_port(input logic [1:0] vc, input logic [5:0] dt);
        if (dt < 6'h28 || dt > 6'h2F) return -1;
        if (vc == cfg_vc0) return 0;
        if (vc == cfg_vc1) return 1;
        return -1;
    endfunction

    task automatic idle_lane(input int ln);
        rx_valid[ln] = 0; rx_sop[ln] = 0; rx_eop[ln] = 0; rx_fend[ln] = 0;
    endtask

    task automatic send_pkt(input int ln, input logic [1:0] vc, input logic [5:0] dt,
                            input int len, input bit fe);
        int ep;
        ep = exp_port(vc, dt);
        for (int b = 0; b < len; b++) begin
            int w;
            @(negedge clk);
            rx_valid[ln] = 1; rx_sop[ln] = (b == 0); rx_eop[ln] = (b == len - 1);
            rx_fend[ln] = fe; rx_vc[ln] = vc; rx_dt[ln] = dt; rx_data[ln] = $urandom;
            #9;
            w = 0;
            while (!rx_ready[ln] && w < 40) begin
                chk(lb_valid == 2'b00, "R9 no output while waiting", lb_valid, 0);
                @(negedge clk); #9; w++;
            end
            chk(rx_ready[ln], "R9 lane never accepted", rx_ready, 2'b11);
            if (ep < 0)
                chk(lb_valid == 2'b00, "R3/R4 dropped packet leaked", lb_valid, 0);
            else begin
                chk(lb_valid == (2'b01 << ep), ep == 0 ? "R1 port A select" : "R2 port B select",
                    lb_valid, 2'b01 << ep);
                chk(lb_data[ep] == rx_data[ln] && lb_sop[ep] == rx_sop[ln] &&
                    lb_eop[ep] == rx_eop[ln] && lb_dt[ep] == dt && lb_fend[ep] == fe,
                    "R1 beat fields", lb_data[ep], rx_data[ln]);
            end
        end
        @(negedge clk);
        idle_lane(ln);
        if (fe && ep >= 0) begin
            #1; chk(grant == 3'b000, "R8 release after frame end", grant, 0);
        end
    endtask

    initial begin
        int rem0, rem1, prev, taken;
        process_init();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk(grant == 0, "R12 grant reset", grant, 0);
        chk(!conflict_err && !dt_err, "R12 flags reset", {conflict_err, dt_err}, 0);
        chk(lb_valid == 0 && rx_ready == 0, "R12 ports reset", {lb_valid, rx_ready}, 0);

        // basic routing
        send_pkt(0, 2'd1, 6'h2A, 3, 0);
        send_pkt(1, 2'd2, 6'h2D, 2, 1);
        // unmatched channels
        send_pkt(0, 2'd3, 6'h2A, 2, 0);
        send_pkt(1, 2'd0, 6'h28, 1, 0);
        #1; chk(!dt_err, "R3 no flag for unmatched channel", dt_err, 0);
        // data type boundaries
        send_pkt(0, 2'd1, 6'h27, 2, 0);
        #1; chk(dt_err, "R4 dt_err after 0x27", dt_err, 1);
        send_pkt(1, 2'd2, 6'h30, 1, 0);
        send_pkt(0, 2'd1, 6'h28, 1, 0);
        send_pkt(1, 2'd2, 6'h2F, 2, 0);

        // round robin: both lanes keep single-beat packets waiting
        rem0 = 3; rem1 = 3; prev = -1;
        for (int g = 0; g < 40 && (rem0 > 0 || rem1 > 0); g++) begin
            bit both;
            @(negedge clk);
            if (rem0 > 0) begin
                rx_valid[0] = 1; rx_sop[0] = 1; rx_eop[0] = 1; rx_fend[0] = 0;
                rx_vc[0] = 2'd1; rx_dt[0] = 6'h2B; rx_data[0] = $urandom;
            end else idle_lane(0);
            if (rem1 > 0) begin
                rx_valid[1] = 1; rx_sop[1] = 1; rx_eop[1] = 1; rx_fend[1] = 0;
                rx_vc[1] = 2'd2; rx_dt[1] = 6'h2B; rx_data[1] = $urandom;
            end else idle_lane(1);
            both = (rem0 > 0 && rem1 > 0);
            #9;
            chk(rx_ready != 2'b11, "R5 both lanes ready", rx_ready, 0);
            if (rx_ready != 0) begin
                taken = rx_ready[1] ? 1 : 0;
                chk(lb_valid == (2'b01 << taken), "R5 single port", lb_valid, 2'b01 << taken);
                if (both && prev >= 0)
                    chk(taken != prev, "R7 round robin alternation", taken, 1 - prev);
                prev = taken;
                if (taken == 1) rem1--; else rem0--;
            end
        end
        chk(rem0 == 0 && rem1 == 0, "R7 all packets served", rem0 + rem1, 0);
        @(negedge clk); idle_lane(0); idle_lane(1);

        // no interleave inside a packet
        @(negedge clk);
        rx_valid[0] = 1; rx_sop[0] = 1; rx_eop[0] = 0; rx_vc[0] = 2'd1; rx_dt[0] = 6'h2C;
        rx_data[0] = 32'hA0;
        #9; chk(rx_ready[0] && lb_valid == 2'b01, "R6 first beat", lb_valid, 1);
        @(negedge clk);
        rx_sop[0] = 0; rx_data[0] = 32'hA1;
        rx_valid[1] = 1; rx_sop[1] = 1; rx_eop[1] = 1; rx_vc[1] = 2'd2; rx_dt[1] = 6'h2C;
        rx_data[1] = 32'hB0;
        #9; chk(!rx_ready[1] && lb_valid == 2'b01, "R6 hold mid packet", {rx_ready, lb_valid}, 4'b0101);
        @(negedge clk);
        rx_eop[0] = 1; rx_data[0] = 32'hA2;
        #9; chk(!rx_ready[1] && lb_valid == 2'b01 && lb_data[0] == 32'hA2, "R6 hold last beat",
                {rx_ready, lb_valid}, 4'b0101);
        @(negedge clk);
        idle_lane(0);
        #9; chk(rx_ready[1] && lb_valid == 2'b10 && lb_data[1] == 32'hB0, "R6 other lane after eop",
                lb_valid, 2'b10);
        @(negedge clk); idle_lane(1);
        send_pkt(0, 2'd1, 6'h2B, 1, 1);

        // constrained random packets, loopback group only
        for (int n = 0; n < 40; n++) begin
            logic [5:0] dt;
            dt = ($urandom % 4 == 0) ? 6'($urandom) : 6'h28 + 6'($urandom % 8);
            send_pkt($urandom % 2, 2'($urandom), dt, 1 + $urandom % 4, ($urandom % 4) == 0);
        end
        send_pkt(0, 2'd1, 6'h2C, 1, 1);
        chk(!conflict_err, "R10 no conflict with loopback alone", conflict_err, 0);

        // exclusivity against DMA
        @(negedge clk); dma_req = 1;
        @(negedge clk); dma_req = 0;
        #1; chk(grant == 3'b001, "R8 DMA granted next cycle", grant, 1);
        chk(!conflict_err, "R10 no conflict on free grant", conflict_err, 0);
        @(negedge clk);
        rx_valid[0] = 1; rx_sop[0] = 1; rx_eop[0] = 1; rx_fend[0] = 1;
        rx_vc[0] = 2'd1; rx_dt[0] = 6'h2A;
        for (int k = 0; k < 3; k++) begin
            #9; chk(!rx_ready[0] && lb_valid == 0, "R9 loopback blocked by DMA", {rx_ready, lb_valid}, 0);
            chk(grant == 3'b001, "R8 DMA grant held", grant, 1);
            @(negedge clk);
        end
        #1; chk(conflict_err, "R10 conflict set", conflict_err, 1);
        idle_lane(0);
        @(negedge clk); dma_fend = 1;
        @(negedge clk); dma_fend = 0;
        #1; chk(grant == 0, "R8 DMA released", grant, 0);
        chk(conflict_err, "R10 conflict sticky", conflict_err, 1);
        @(negedge clk); cbar_req = 1;
        @(negedge clk); cbar_req = 0;
        #1; chk(grant == 3'b010, "R8 colour bar granted", grant, 2);
        @(negedge clk); cbar_fend = 1;
        @(negedge clk); cbar_fend = 0;
        @(negedge clk); dma_req = 1; cbar_req = 1;
        @(negedge clk); dma_req = 0; cbar_req = 0;
        #1; chk(grant == 3'b001, "R11 DMA beats colour bar", grant, 1);
        @(negedge clk); dma_fend = 1;
        @(negedge clk); dma_fend = 0;
        @(negedge clk); cbar_req = 1;
        rx_valid[1] = 1; rx_sop[1] = 1; rx_eop[1] = 1; rx_fend[1] = 1;
        rx_vc[1] = 2'd2; rx_dt[1] = 6'h2A;
        @(negedge clk); cbar_req = 0; idle_lane(1);
        #1; chk(grant == 3'b010, "R11 colour bar beats loopback", grant, 2);
        @(negedge clk); cbar_fend = 1;
        @(negedge clk); cbar_fend = 0;
        send_pkt(1, 2'd2, 6'h29, 2, 1);
        chk(conflict_err && dt_err, "R10 flags still set", {conflict_err, dt_err}, 3);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    task automatic process_init();
        cfg_vc0 = 2'd1; cfg_vc1 = 2'd2;
        rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_fend = 0;
        rx_vc = '0; rx_dt = '0; rx_data = '0;
        dma_req = 0; dma_fend = 0; cbar_req = 0; cbar_fend = 0;
        void'($urandom(32'd2024));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nvec++; nerr++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule